// File: doc/BRIEF.md
# Paged External Bus Window

This block lets a CPU with a 16-bit address space reach a 1 MB external bus through one 256-byte window. The window sits at a fixed CPU page. Another CPU page holds a small set of byte-wide bank registers. Together these registers give the upper twelve external address lines. One more register bit decides whether an access through the window runs as a memory cycle or an I/O cycle on the external side.

A CPU access that lands in the window goes straight out. The low eight external address bits are the low eight CPU address bits. The upper bits come from the stored page value. The block raises exactly one of four external strobes, chosen by the CPU read/write signal and the I/O select bit. An access to the register page reads or writes the bank registers. Such an access never produces an external strobe. Software moves the window by rewriting the page registers between accesses. A new value is used from the following bus cycle onward.

Top module: `bus_window_bank`

## Requirements
- R1: After reset, all bank registers hold zero. Register reads return 0x00, and a window access drives external address bits [19:8] to zero.
- R2: During a window access (CPU address bits [15:8] equal to the window page), the external address is {page_hi[3:0], page_lo[7:0], cpu_addr[7:0]}.
- R3: Register index 0 (CPU address bits [1:0] = 0 within the register page) stores all eight written bits as page_lo, and reads return them unchanged.
- R4: Register index 1 stores the low nibble of the written byte as page_hi. A read returns that nibble in bits [3:0], with bits [7:4] reading as zero.
- R5: Register index 2 bit 0 is the I/O select (1 = I/O cycles, 0 = memory cycles). A read returns it in bit 0, with bits [7:1] reading as zero.
- R6: Register index 3 reads as 0x00, and writing it changes none of the stored register values.
- R7: No external strobe is asserted unless cpu_valid is high and the CPU address is inside the window. This includes register-page accesses and all other pages.
- R8: With I/O select at 0, a window read raises ext_mem_rd and a window write raises ext_mem_wr. With I/O select at 1, they raise ext_io_rd and ext_io_wr instead.
- R9: A register write is captured at the clock edge that ends its cycle. The next bus cycle already uses the new value. A cycle without a register write leaves all registers unchanged.
- R10: At most one of the four external strobes is high in any cycle.
- R11: cpu_rdata is 0x00 in every cycle that is not a register-page read.
- R12: The four registers repeat throughout the register page. Only CPU address bits [1:0] select the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU bus cycle active this clock |
| cpu_we | input | 1 | 1 = CPU write, 0 = CPU read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register read data (zero otherwise) |
| ext_addr | output | 20 | External address |
| ext_mem_rd | output | 1 | External memory read strobe |
| ext_mem_wr | output | 1 | External memory write strobe |
| ext_io_rd | output | 1 | External I/O read strobe |
| ext_io_wr | output | 1 | External I/O write strobe |

## Verification
Two functions meet at the same clock edge: a register update and a window translation that depends on it. The bench issues a page or I/O-select write and follows it immediately with a window access in the next cycle. It expects the new page bits and the new strobe type there. During the write cycle itself it expects no strobe. It also pairs register writes with read-back in the following cycle, across the mirrored register addresses. This shows that one cycle of latency is exact and that no stale value leaks through.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  typedef enum logic [1:0] {
    IDX_PAGE_LO = 2'd0,
    IDX_PAGE_HI = 2'd1,
    IDX_CTRL    = 2'd2,
    IDX_SPARE   = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } strobe_t;

  // Strobe choice: only a live window access produces one, kind set by io_sel.
  function automatic strobe_t pick_strobe(logic live, logic we, logic io_sel);
    strobe_t s;
    s.mem_rd = live & ~we & ~io_sel;
    s.mem_wr = live &  we & ~io_sel;
    s.io_rd  = live & ~we &  io_sel;
    s.io_wr  = live &  we &  io_sel;
    return s;
  endfunction

  // External address: page bits above, CPU low byte below.
  function automatic logic [31:0] join_addr(logic [15:0] page, logic [7:0] lo);
    return {8'h00, page, lo};
  endfunction

endpackage

// File: rtl/bwb_decode.sv
module bwb_decode #(
  parameter int          CPU_AW   = 16,
  parameter int unsigned WIN_PAGE = 'hDE,
  parameter int unsigned REG_PAGE = 'hDF
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic              win_hit,
  output logic              reg_hit,
  output bwb_pkg::reg_idx_e reg_idx
);
  localparam int PG_W = CPU_AW - 8;

  logic [PG_W-1:0] page_bits;
  assign page_bits = cpu_addr[CPU_AW-1:8];

  assign win_hit = (page_bits == PG_W'(WIN_PAGE));
  assign reg_hit = (page_bits == PG_W'(REG_PAGE));
  assign reg_idx = bwb_pkg::reg_idx_e'(cpu_addr[1:0]);
endmodule

// File: rtl/bwb_regs.sv
module bwb_regs #(
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  bwb_pkg::reg_idx_e idx,
  input  logic [7:0]        wdata,
  output logic [PAGE_W-1:0] page_q,
  output logic              io_q,
  output logic [7:0]        rd_raw
);
  localparam int HI_W = PAGE_W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  logic [7:0]      hi_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      io_q <= 1'b0;
    end else if (wr_en) begin
      case (idx)
        bwb_pkg::IDX_PAGE_LO: lo_q <= wdata;
        bwb_pkg::IDX_PAGE_HI: hi_q <= wdata[HI_W-1:0];
        bwb_pkg::IDX_CTRL:    io_q <= wdata[0];
        default: ;
      endcase
    end
  end

  generate
    if (HI_W < 8) begin : g_hi_pad
      assign hi_rd = {{(8 - HI_W){1'b0}}, hi_q};
    end else begin : g_hi_full
      assign hi_rd = hi_q[7:0];
    end
  endgenerate

  assign page_q = {hi_q, lo_q};

  always_comb begin
    case (idx)
      bwb_pkg::IDX_PAGE_LO: rd_raw = lo_q;
      bwb_pkg::IDX_PAGE_HI: rd_raw = hi_rd;
      bwb_pkg::IDX_CTRL:    rd_raw = {7'b0, io_q};
      default:              rd_raw = 8'h00;
    endcase
  end
endmodule

// File: rtl/bwb_strobe.sv
module bwb_strobe (
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic             win_hit,
  input  logic             io_sel,
  output bwb_pkg::strobe_t stb
);
  logic live;
  assign live = cpu_valid & win_hit;
  assign stb  = bwb_pkg::pick_strobe(live, cpu_we, io_sel);
endmodule

// File: rtl/bus_window_bank.sv
module bus_window_bank #(
  parameter int          CPU_AW   = 16,
  parameter int          PAGE_W   = 12,
  parameter int unsigned WIN_PAGE = 'hDE,
  parameter int unsigned REG_PAGE = 'hDF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  input  logic                cpu_we,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [7:0]          cpu_wdata,
  output logic [7:0]          cpu_rdata,
  output logic [PAGE_W+7:0]   ext_addr,
  output logic                ext_mem_rd,
  output logic                ext_mem_wr,
  output logic                ext_io_rd,
  output logic                ext_io_wr
);
  localparam int EXT_W = PAGE_W + 8;

  logic              win_hit;
  logic              reg_hit;
  bwb_pkg::reg_idx_e reg_idx;
  logic              reg_wr;
  logic              reg_rd;
  logic [PAGE_W-1:0] page_q;
  logic              io_q;
  logic [7:0]        rd_raw;
  bwb_pkg::strobe_t  stb;
  logic [31:0]       joined;

  bwb_decode #(
    .CPU_AW(CPU_AW), .WIN_PAGE(WIN_PAGE), .REG_PAGE(REG_PAGE)
  ) u_dec (
    .cpu_addr(cpu_addr), .win_hit(win_hit), .reg_hit(reg_hit), .reg_idx(reg_idx)
  );

  assign reg_wr = cpu_valid & cpu_we & reg_hit;
  assign reg_rd = cpu_valid & ~cpu_we & reg_hit;

  bwb_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_idx),
    .wdata(cpu_wdata), .page_q(page_q), .io_q(io_q), .rd_raw(rd_raw)
  );

  bwb_strobe u_stb (
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .win_hit(win_hit),
    .io_sel(io_q), .stb(stb)
  );

  assign joined     = bwb_pkg::join_addr(16'(page_q), cpu_addr[7:0]);
  assign ext_addr   = joined[EXT_W-1:0];
  assign cpu_rdata  = reg_rd ? rd_raw : 8'h00;
  assign ext_mem_rd = stb.mem_rd;
  assign ext_mem_wr = stb.mem_wr;
  assign ext_io_rd  = stb.io_rd;
  assign ext_io_wr  = stb.io_wr;
endmodule

// File: rtl/bwb_checker.sv
module bwb_checker #(
  parameter int CPU_AW = 16,
  parameter int PAGE_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_valid,
  input logic                cpu_we,
  input logic [CPU_AW-1:0]   cpu_addr,
  input logic [7:0]          cpu_wdata,
  input logic [7:0]          cpu_rdata,
  input logic [PAGE_W+7:0]   ext_addr,
  input logic                ext_mem_rd,
  input logic                ext_mem_wr,
  input logic                ext_io_rd,
  input logic                ext_io_wr,
  input logic                win_hit,
  input logic                reg_hit,
  input logic                reg_wr,
  input logic [PAGE_W-1:0]   page_q,
  input logic                io_q
);
  logic [3:0] strobes;
  assign strobes = {ext_mem_rd, ext_mem_wr, ext_io_rd, ext_io_wr};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes)); // R10

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && win_hit) |-> (strobes == 4'b0000)); // R7

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes != 4'b0000) |-> (ext_addr[7:0] == cpu_addr[7:0])); // R2

  AST_IO_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (io_q && strobes != 4'b0000) |-> (!ext_mem_rd && !ext_mem_wr)); // R8

  AST_PAGE_LO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cpu_addr[1:0] == 2'd0) |=> (page_q[7:0] == $past(cpu_wdata))); // R9

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(page_q) && $stable(io_q))); // R9

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && !cpu_we && reg_hit) |-> (cpu_rdata == 8'h00)); // R11

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_we && reg_hit && cpu_addr[1:0] == 2'd3) |-> (cpu_rdata == 8'h00)); // R6
endmodule

bind bus_window_bank bwb_checker #(.CPU_AW(CPU_AW), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .ext_addr(ext_addr), .ext_mem_rd(ext_mem_rd), .ext_mem_wr(ext_mem_wr),
  .ext_io_rd(ext_io_rd), .ext_io_wr(ext_io_wr), .win_hit(win_hit),
  .reg_hit(reg_hit), .reg_wr(reg_wr), .page_q(page_q), .io_q(io_q)
);

// File: tb/bus_window_bank_tb_top.sv
module bus_window_bank_tb_top;
  localparam logic [7:0] WIN = 8'hDE;
  localparam logic [7:0] RGP = 8'hDF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [19:0] ext_addr;
  logic        ext_mem_rd, ext_mem_wr, ext_io_rd, ext_io_wr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_lo = 8'h00;
  logic [3:0] m_hi = 4'h0;
  logic       m_io = 1'b0;

  always #5 clk = ~clk;

  bus_window_bank dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ext_addr(ext_addr), .ext_mem_rd(ext_mem_rd), .ext_mem_wr(ext_mem_wr),
    .ext_io_rd(ext_io_rd), .ext_io_wr(ext_io_wr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (addr=%h)", req, act, exp, cpu_addr);
    end
  endtask

  // Drive a bus cycle at the falling edge, then settle for combinational outputs.
  task automatic cyc(logic v, logic we, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_valid = v; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
  endtask

  function automatic logic [3:0] exp_stb(logic v, logic we, logic [15:0] a, logic io);
    if (!v || a[15:8] != WIN) return 4'b0000;
    if (io) return we ? 4'b0001 : 4'b0010;
    return we ? 4'b0100 : 4'b1000;
  endfunction

  function automatic logic [3:0] got_stb();
    return {ext_mem_rd, ext_mem_wr, ext_io_rd, ext_io_wr};
  endfunction

  // Register write with model update after the capturing edge.
  task automatic wr_reg(logic [7:0] lo_addr, logic [7:0] d);
    cyc(1'b1, 1'b1, {RGP, lo_addr}, d);
    chk("R7 no strobe on register write", {28'd0, got_stb()}, 32'd0);
    chk("R11 rdata zero on write", {24'd0, cpu_rdata}, 32'd0);
    case (lo_addr[1:0])
      2'd0: m_lo = d;
      2'd1: m_hi = d[3:0];
      2'd2: m_io = d[0];
      default: ;
    endcase
  endtask

  task automatic rd_reg(string req, logic [7:0] lo_addr, logic [7:0] exp);
    cyc(1'b1, 1'b0, {RGP, lo_addr}, 8'h00);
    chk(req, {24'd0, cpu_rdata}, {24'd0, exp});
  endtask

  task automatic win_acc(string req, logic we, logic [7:0] lo);
    cyc(1'b1, we, {WIN, lo}, 8'h5A);
    chk(req, {12'd0, ext_addr}, {12'd0, m_hi, m_lo, lo});
    chk("R8 strobe kind", {28'd0, got_stb()}, {28'd0, exp_stb(1'b1, we, {WIN, lo}, m_io)});
    chk("R11 rdata zero in window", {24'd0, cpu_rdata}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) rd_reg("R1 reset readback", 8'(i), 8'h00);
    win_acc("R1 reset page zero", 1'b0, 8'h7F);

    // R3 page_lo full byte, using mirrored addresses (R12)
    for (int v = 0; v < 256; v++) begin
      wr_reg(8'(v) & 8'hFC, 8'(v));
      rd_reg("R3 page_lo readback", 8'hFC - (8'(v) & 8'hFC), 8'(v));
    end
    // R4 page_hi nibble
    for (int v = 0; v < 256; v++) begin
      wr_reg((8'(v) & 8'hFC) | 8'h01, 8'(v));
      rd_reg("R4 page_hi readback", 8'h01, {4'h0, 4'(v)});
    end
    // R5 io select bit
    for (int v = 0; v < 256; v++) begin
      wr_reg(8'h02, 8'(v));
      rd_reg("R5 ctrl readback", (8'(v) & 8'hFC) | 8'h02, {7'd0, v[0]});
    end
    // R6 spare register
    wr_reg(8'h00, 8'hC3); wr_reg(8'h01, 8'h09); wr_reg(8'h02, 8'h00);
    for (int v = 0; v < 256; v += 17) begin
      wr_reg(8'h03, 8'(v));
      rd_reg("R6 spare reads zero", 8'h03, 8'h00);
      rd_reg("R6 lo unchanged", 8'h00, 8'hC3);
      rd_reg("R6 hi unchanged", 8'h01, 8'h09);
      rd_reg("R6 ctrl unchanged", 8'h02, 8'h00);
    end

    // R2 / R8 window sweep across pages and cycle kinds
    for (int io = 0; io < 2; io++) begin
      for (int p = 0; p < 4; p++) begin
        logic [11:0] pg;
        pg = (p == 0) ? 12'h000 : (p == 1) ? 12'hFFF : (p == 2) ? 12'hA5C : 12'h3C1;
        wr_reg(8'h00, pg[7:0]);
        wr_reg(8'h01, {4'h0, pg[11:8]});
        wr_reg(8'h02, 8'(io));
        for (int lo = 0; lo < 256; lo++) begin
          win_acc("R2 window address", 1'b0, 8'(lo));
          win_acc("R2 window address", 1'b1, 8'(lo));
        end
      end
    end

    // R7 every CPU page, reads and writes, plus idle cycles in the window
    for (int hi = 0; hi < 256; hi++) begin
      if (8'(hi) == RGP) continue;
      for (int we = 0; we < 2; we++) begin
        cyc(1'b1, we[0], {8'(hi), 8'(hi) ^ 8'h5A}, 8'h11);
        chk("R7 strobe only in window", {28'd0, got_stb()},
            {28'd0, exp_stb(1'b1, we[0], {8'(hi), 8'h00}, m_io)});
        chk("R11 rdata zero off register page", {24'd0, cpu_rdata}, 32'd0);
      end
    end
    cyc(1'b0, 1'b0, {WIN, 8'h10}, 8'h00);
    chk("R7 idle in window", {28'd0, got_stb()}, 32'd0);
    cyc(1'b0, 1'b1, {RGP, 8'h00}, 8'hEE);
    rd_reg("R9 idle write ignored", 8'h00, m_lo);

    // R9 back-to-back: register write then window access next cycle
    wr_reg(8'h00, 8'h33);
    win_acc("R9 new page_lo next cycle", 1'b0, 8'h44);
    wr_reg(8'h01, 8'h07);
    win_acc("R9 new page_hi next cycle", 1'b1, 8'hA0);
    wr_reg(8'h02, 8'h01);
    win_acc("R9 io select next cycle", 1'b0, 8'h01);
    wr_reg(8'h02, 8'h00);
    win_acc("R9 mem select next cycle", 1'b1, 8'hFE);

    // R1 reset again clears state
    @(negedge clk); rst_n = 1'b0; cpu_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_lo = 8'h00; m_hi = 4'h0; m_io = 1'b0;
    for (int i = 0; i < 4; i++) rd_reg("R1 re-reset readback", 8'(i), 8'h00);

    cyc(1'b0, 1'b0, 16'h0000, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule